// File: doc/BRIEF.md
# JTAG-to-SPI Flash Bridge

This block turns the bits a host shifts through a one-bit user data register of a boundary-scan chain into one SPI flash transaction. It sits on the user side of a TAP. It takes the select, capture, shift and update strobes, TDI and the TCK clock, and it returns TDO. It drives a SPI master port made of SCLK, an active-low chip select, MOSI and MISO. Everything runs in the TCK domain. SCLK is TCK passed through a clock gate that is enabled only during the counted transfer.

A frame, as the bridge sees it, starts with a run of zeros of any length. These zeros are what the bypass registers of upstream TAPs push out after capture. The first one bit is a start flag, and the bridge does not forward it. The next 32 bits give the number of SPI clocks, most significant bit first. That many TDI bits then go out on MOSI with chip select low. Each MISO bit goes back onto TDO one TCK later. Any bits shifted in after the counted clocks are ignored until the host returns the bridge to its idle search. The host does this by selecting the register again, by a capture, or by an update. Because of this, a host can read back the flash data through any number of bypassed TAPs that follow the bridge.

Top module: `jtag_spi_bridge`

## Requirements
- R1: While trst_n is low, and right after it, cs_n is 1, sclk is 0 and tdo is 0.
- R2: After a capture, zero bits on tdi are skipped. The first 1 bit is a start flag: it produces no SCLK edge and does not appear on MOSI.
- R3: The 32 tdi bits after the start flag form the transfer length, most significant bit first. A frame with length 257 gives exactly 257 SCLK rising edges.
- R4: A frame of length L gives exactly L SCLK rising edges inside a single low period of cs_n. At rising edge i, MOSI carries data bit i, which is the tdi bit that follows the length field by i positions.
- R5: A length of zero gives no SCLK edge, and cs_n stays high for the whole frame, including any bits that follow.
- R6: Once the counted clocks are done, further shift cycles never start a new transfer, even when they contain 1 bits.
- R7: A capture, an update or a deassertion of sel sends the bridge back to searching for the start flag. A partial length field that was interrupted this way has no effect on the next frame. When sel falls during a transfer, cs_n is high by the next falling TCK edge.
- R8: When shift falls during a transfer, SCLK stops and cs_n is high by the next falling TCK edge. Only the data bits already taken are clocked out.
- R9: Outside a transfer, tdo is tdi delayed by one rising TCK edge, which makes the register one bit long. A capture loads tdo with 0.
- R10: MISO is sampled on the rising TCK edge, which is the SCLK edge opposite the one the flash drives it on. It appears on tdo after that edge. Data bit i therefore reaches tdo 34 + i rising edges after the bridge takes the start flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock; all state advances on its rising edge |
| trst_n | input | 1 | Asynchronous TAP reset, active low |
| sel | input | 1 | The bridge's user instruction is selected |
| capture | input | 1 | TAP is in Capture-DR |
| shift | input | 1 | TAP is in Shift-DR |
| update | input | 1 | TAP is in Update-DR |
| tdi | input | 1 | Serial data from the chain |
| tdo | output | 1 | One-bit data register output toward the chain |
| sclk | output | 1 | Gated SPI clock |
| cs_n | output | 1 | SPI chip select, active low |
| mosi | output | 1 | SPI data toward the flash |
| miso | input | 1 | SPI data from the flash |

## Verification
The properties assume that sel, capture, shift, update and tdi change only just after a rising TCK edge, the way TAP controller outputs do. They also assume that capture, shift and update are never high together, and that trst_n is held low across several edges at start-up. The bench drives every input 1 ns after the rising edge and moves the TAP phase through separate capture, shift, exit and update steps, so these assumptions always hold. Bypass registers on both sides of the bridge are modelled as shift flops that clear on capture, so the leading zeros and the readback delay come from the same chain a host would see.

// File: rtl/jsb_pkg.sv
package jsb_pkg;

    // Frame phases of the bridge
    typedef enum logic [1:0] {
        PH_HUNT = 2'd0,   // waiting for the start flag
        PH_LEN  = 2'd1,   // collecting the length field
        PH_XFER = 2'd2,   // counted SPI clocks running
        PH_DONE = 2'd3    // counted clocks finished, ignore rest
    } jsb_phase_e;

endpackage

// File: rtl/jsb_frame.sv
module jsb_frame
    import jsb_pkg::*;
#(
    parameter int LEN_W = 32
) (
    input  logic tck,
    input  logic trst_n,
    input  logic sel,
    input  logic capture,
    input  logic update,
    input  logic shift,
    input  logic tdi,
    output logic xfer,
    output logic tail,
    output logic in_hunt,
    output logic in_done
);
    localparam int CNT_W = $clog2(LEN_W);

    typedef struct packed {
        jsb_phase_e          phase;
        logic [CNT_W-1:0]    bits;
        logic [LEN_W-1:0]    remain;
    } frame_s;

    localparam frame_s FRAME_RST = '{phase: PH_HUNT, bits: '0, remain: '0};

    frame_s frm_d, frm_q;
    logic [LEN_W-1:0] len_next;

    always_comb begin
        frm_d    = frm_q;
        len_next = {frm_q.remain[LEN_W-2:0], tdi};   // R3: MSB arrives first
        if (!sel || capture || update) begin
            // R7: any fresh scan restarts the search for the start flag
            frm_d = FRAME_RST;
        end else if (!shift) begin
            // R8: leaving Shift-DR ends a running transfer
            if (frm_q.phase == PH_XFER) begin
                frm_d.phase  = PH_DONE;
                frm_d.remain = '0;
            end
        end else begin
            unique case (frm_q.phase)
                PH_HUNT: begin
                    // R2: zeros are skipped, first one is consumed as the flag
                    if (tdi) begin
                        frm_d.phase  = PH_LEN;
                        frm_d.bits   = '0;
                        frm_d.remain = '0;
                    end
                end
                PH_LEN: begin
                    frm_d.remain = len_next;
                    frm_d.bits   = frm_q.bits + 1'b1;
                    if (frm_q.bits == CNT_W'(LEN_W - 1)) begin
                        // R5: a zero length skips the transfer entirely
                        frm_d.phase = (len_next == '0) ? PH_DONE : PH_XFER;
                    end
                end
                PH_XFER: begin
                    // R4: one count per SPI clock
                    frm_d.remain = frm_q.remain - 1'b1;
                    if (frm_q.remain == LEN_W'(1)) begin
                        frm_d.phase = PH_DONE;
                    end
                end
                default: begin
                    // R6: PH_DONE holds until a new scan
                end
            endcase
        end
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) frm_q <= FRAME_RST;
        else         frm_q <= frm_d;
    end

    assign xfer    = (frm_q.phase == PH_XFER);
    assign tail    = (frm_q.phase == PH_XFER) || (frm_q.phase == PH_DONE);
    assign in_hunt = (frm_q.phase == PH_HUNT);
    assign in_done = (frm_q.phase == PH_DONE);

endmodule

// File: rtl/jsb_sclk_gate.sv
module jsb_sclk_gate (
    input  logic tck,
    input  logic trst_n,
    input  logic xfer,
    input  logic sel,
    input  logic shift,
    output logic sclk,
    output logic cs_n
);
    logic gate_d, gate_q;

    // Enable is taken on the falling edge so sclk never glitches while tck is high
    always_comb gate_d = xfer & sel & shift;

    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) gate_q <= 1'b0;
        else         gate_q <= gate_d;
    end

    assign sclk = tck & gate_q;
    assign cs_n = ~gate_q;

endmodule

// File: rtl/jsb_return.sv
module jsb_return (
    input  logic tck,
    input  logic trst_n,
    input  logic capture,
    input  logic tail,
    input  logic miso,
    input  logic tdi,
    output logic tdo
);
    logic tdo_d, tdo_q;

    always_comb begin
        if (capture)   tdo_d = 1'b0;   // R9
        else if (tail) tdo_d = miso;   // R10
        else           tdo_d = tdi;    // R9: one-bit register
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) tdo_q <= 1'b0;
        else         tdo_q <= tdo_d;
    end

    assign tdo = tdo_q;

endmodule

// File: rtl/jtag_spi_bridge.sv
module jtag_spi_bridge #(
    parameter int LEN_W = 32
) (
    input  logic tck,
    input  logic trst_n,
    input  logic sel,
    input  logic capture,
    input  logic shift,
    input  logic update,
    input  logic tdi,
    output logic tdo,
    output logic sclk,
    output logic cs_n,
    output logic mosi,
    input  logic miso
);
    logic xfer_w, tail_w, in_hunt, in_done;

    jsb_frame #(.LEN_W(LEN_W)) frame_i (
        .tck     (tck),
        .trst_n  (trst_n),
        .sel     (sel),
        .capture (capture),
        .update  (update),
        .shift   (shift),
        .tdi     (tdi),
        .xfer    (xfer_w),
        .tail    (tail_w),
        .in_hunt (in_hunt),
        .in_done (in_done)
    );

    jsb_sclk_gate gate_i (
        .tck    (tck),
        .trst_n (trst_n),
        .xfer   (xfer_w),
        .sel    (sel),
        .shift  (shift),
        .sclk   (sclk),
        .cs_n   (cs_n)
    );

    jsb_return ret_i (
        .tck     (tck),
        .trst_n  (trst_n),
        .capture (capture),
        .tail    (tail_w),
        .miso    (miso),
        .tdi     (tdi),
        .tdo     (tdo)
    );

    // R4: data passes straight to the flash, sampled on the same edge as tdi
    assign mosi = tdi;

endmodule

// File: rtl/jsb_props.sv
module jsb_props (
    input logic tck,
    input logic trst_n,
    input logic sel,
    input logic capture,
    input logic update,
    input logic shift,
    input logic tdi,
    input logic tdo,
    input logic cs_n,
    input logic in_hunt,
    input logic in_done
);
    // R7
    capture_rehunt_chk: assert property (@(posedge tck) disable iff (!trst_n)
        capture |=> in_hunt);

    // R7
    deselect_cs_chk: assert property (@(negedge tck) disable iff (!trst_n)
        !sel |=> cs_n);

    // R8
    shift_exit_cs_chk: assert property (@(negedge tck) disable iff (!trst_n)
        !shift |=> cs_n);

    // R6
    done_sticky_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (in_done && sel && shift && !capture && !update) |=> in_done);

    // R9
    one_bit_delay_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (in_hunt && sel && shift && !capture) |=> (tdo == $past(tdi)));

endmodule

bind jtag_spi_bridge jsb_props props_i (
    .tck     (tck),
    .trst_n  (trst_n),
    .sel     (sel),
    .capture (capture),
    .update  (update),
    .shift   (shift),
    .tdi     (tdi),
    .tdo     (tdo),
    .cs_n    (cs_n),
    .in_hunt (in_hunt),
    .in_done (in_done)
);

// File: tb/jtag_spi_bridge_tb_top.sv
`timescale 1ns/100ps
module jtag_spi_bridge_tb_top;
    localparam int NB = 2;          // bypassed TAPs ahead of the bridge
    localparam int NA = 3;          // bypassed TAPs behind the bridge
    localparam int DEPTH = 1024;

    logic tck = 1'b0;
    logic trst_n = 1'b0;
    logic sel = 1'b0, capture = 1'b0, shift = 1'b0, update = 1'b0;
    logic host_tdi = 1'b0;
    logic tdo, sclk, cs_n, mosi;
    logic miso = 1'b0;

    logic [NB-1:0] pre_q = '0;
    logic [NA-1:0] post_q = '0;

    int checks = 0, fails = 0;
    int sclk_cnt = 0, frm_cnt = 0;
    logic fb   [DEPTH];
    logic rx   [DEPTH];
    logic dtdo [DEPTH];
    logic sb   [DEPTH];
    logic last_mosi = 1'b0;

    always #2.5 tck = ~tck;   // 200 MHz

    jtag_spi_bridge dut_i (
        .tck(tck), .trst_n(trst_n), .sel(sel), .capture(capture),
        .shift(shift), .update(update), .tdi(pre_q[NB-1]), .tdo(tdo),
        .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso)
    );

    // bypass chain around the bridge
    always @(posedge tck) begin
        if (capture) begin
            pre_q  <= '0;
            post_q <= '0;
        end else if (shift) begin
            pre_q  <= {pre_q[NB-2:0], host_tdi};
            post_q <= {post_q[NA-2:0], tdo};
        end
    end

    // flash echo model: takes MOSI on rising SCLK, returns it on falling SCLK
    always @(posedge sclk) begin
        if (!cs_n) begin
            fb[sclk_cnt % DEPTH] = mosi;
            last_mosi = mosi;
            sclk_cnt++;
        end
    end
    always @(negedge sclk) miso <= last_mosi;
    always @(negedge cs_n) frm_cnt++;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic bit pat(input int i, input int s);
        return ((i * 7 + s * 3 + (i >> 2)) % 3) == 0;
    endfunction

    task automatic step();
        @(posedge tck);
        #1;
    endtask

    // One capture, then a shifted frame; cs_after is cs_n right after the phase exit
    task automatic send_frame(input int len, input int ndata, input int trail,
                              input bit tv, input int s, input bit drop_sel,
                              output int total, output logic cs_after);
        logic [31:0] lv;
        lv = len;
        total = 33 + ndata + trail;
        for (int t = 0; t < total; t++) begin
            if (t == 0)            sb[t] = 1'b1;
            else if (t <= 32)      sb[t] = lv[32 - t];
            else if (t < 33+ndata) sb[t] = pat(t - 33, s);
            else                   sb[t] = tv;
        end
        sel = 1'b1; shift = 1'b0; capture = 1'b1;
        step();
        capture = 1'b0; shift = 1'b1;
        for (int t = 0; t < total; t++) begin
            host_tdi = sb[t];
            step();
            rx[t]   = post_q[NA-1];
            dtdo[t] = tdo;
        end
        if (drop_sel) sel = 1'b0;
        else          shift = 1'b0;
        step();
        cs_after = cs_n;
        shift = 1'b0; sel = 1'b1; update = 1'b1;
        step();
        update = 1'b0;
        host_tdi = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 cs_n in reset", cs_n, 1);
        chk("R1 sclk in reset", sclk, 0);
        chk("R1 tdo in reset", tdo, 0);
    endtask

    task automatic t_full(input int len, input int s, input string tag);
        int c0, f0, total, bad9, bad10, bad4;
        logic csa;
        c0 = sclk_cnt; f0 = frm_cnt;
        bad9 = 0; bad10 = 0; bad4 = 0;
        send_frame(len, len, NB + NA + 2, 1'b0, s, 1'b0, total, csa);
        chk({tag, " R4 sclk count"}, sclk_cnt - c0, len);
        chk({tag, " R4 single cs_n low period"}, frm_cnt - f0, 1);
        chk({tag, " R4 cs_n released"}, csa, 1);
        for (int i = 0; i < len; i++)
            if (fb[(c0 + i) % DEPTH] !== pat(i, s)) bad4++;
        // R2: first MOSI bit is data bit 0, never the start flag
        chk({tag, " R2 R4 mosi bits wrong"}, bad4, 0);
        for (int t = 0; t <= NB + 32; t++)
            if (dtdo[t] !== ((t < NB) ? 1'b0 : sb[t - NB])) bad9++;
        chk({tag, " R9 one-bit delay mismatches"}, bad9, 0);
        for (int i = 0; i < len; i++)
            if (rx[NB + NA + 34 + i] !== pat(i, s)) bad10++;
        chk({tag, " R10 readback alignment mismatches"}, bad10, 0);
    endtask

    task automatic t_zero();
        int c0, f0, total;
        logic csa;
        c0 = sclk_cnt; f0 = frm_cnt;
        send_frame(0, 0, 20, 1'b1, 1, 1'b0, total, csa);
        chk("R5 zero length sclk", sclk_cnt - c0, 0);
        chk("R5 zero length cs_n never low", frm_cnt - f0, 0);
    endtask

    task automatic t_trail_ones();
        int c0, f0, total;
        logic csa;
        c0 = sclk_cnt; f0 = frm_cnt;
        send_frame(4, 4, NB + NA + 40, 1'b1, 2, 1'b0, total, csa);
        chk("R6 trailing ones sclk", sclk_cnt - c0, 4);
        chk("R6 trailing ones frames", frm_cnt - f0, 1);
    endtask

    task automatic t_rehunt();
        int c0, total;
        logic csa;
        sel = 1'b1; capture = 1'b1; step();
        capture = 1'b0; shift = 1'b1;
        for (int t = 0; t < 12; t++) begin
            host_tdi = 1'b1;   // flag plus part of a length field
            step();
        end
        shift = 1'b0; host_tdi = 1'b0; step();
        c0 = sclk_cnt;
        send_frame(5, 5, NB + NA + 2, 1'b0, 3, 1'b0, total, csa);
        chk("R7 capture rehunt sclk", sclk_cnt - c0, 5);
    endtask

    task automatic t_deselect();
        int c0, total;
        logic csa;
        c0 = sclk_cnt;
        send_frame(12, 12, 0, 1'b0, 4, 1'b1, total, csa);
        chk("R7 deselect cs_n", csa, 1);
        chk("R7 deselect sclk", sclk_cnt - c0, 12 - NB);
    endtask

    task automatic t_abort();
        int c0, total;
        logic csa;
        c0 = sclk_cnt;
        send_frame(20, 20, 0, 1'b0, 5, 1'b0, total, csa);
        chk("R8 shift exit cs_n", csa, 1);
        chk("R8 shift exit sclk", sclk_cnt - c0, 20 - NB);
        step();
        chk("R8 sclk quiet after exit", sclk_cnt - c0, 20 - NB);
    endtask

    task automatic t_capture_tdo();
        sel = 1'b1; shift = 1'b1; host_tdi = 1'b0;
        step();
        shift = 1'b0; capture = 1'b1;
        step();
        capture = 1'b0;
        chk("R9 capture loads zero", tdo, 0);
        step();
    endtask

    initial begin
        repeat (3) step();
        t_reset();
        trst_n = 1'b1;
        step();
        t_capture_tdo();
        t_full(8, 1, "len8");
        t_full(257, 6, "len257 R3");
        t_zero();
        t_trail_ones();
        t_rehunt();
        t_deselect();
        t_abort();
        repeat (4) step();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule